// File: doc/BRIEF.md
# Multicycle Accumulator Word-Add Engine

This block is a small microprogrammed accumulator machine that runs a single 16-bit instruction over and over: it adds an 8-bit immediate to the register pair formed by R31 (high byte) and R30 (low byte). The datapath is deliberately narrow. It has one internal bus, a register file that reads one register per cycle, an 8-bit accumulator, an 8-bit instruction register, an 8-bit memory data register, and a 16-bit program counter and memory address register. Only the program counter and the accumulator can increment themselves.

Every instruction takes exactly eleven cycles. The first five fetch the two instruction bytes from a byte-wide synchronous memory. The next six perform the add one byte at a time: the low byte first, then the high byte, which adds zero plus the carry left by the low byte. The instruction's opcode byte is compared against a parameter. Any other opcode still takes the full eleven cycles but changes nothing. A one-cycle done pulse marks the final execute cycle, and the engine then goes straight back to fetch at the next address.

The pair value is brought out on a port so that the result can be seen without extra instructions.

Top module: `wadd_cpu`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, pair_o is 0, carry_o is 0, done_o is 0 and mem_rd_o is 0. The first instruction byte is read from address 0.
- R2: Every instruction takes exactly 11 cycles. done_o is high only in the 11th cycle, for one cycle, and the next instruction's fetch starts in the following cycle.
- R3: An instruction occupies two consecutive byte addresses. The immediate is at the lower (even) address and the opcode at the higher one. Read addresses advance by one per read across the whole program.
- R4: mem_rd_o is high in exactly cycles 2 and 3 of each instruction (counting from 1). Memory data is expected one cycle after the read strobe.
- R5: With opcode OPCODE (default 8'h3C), the new value of {R31,R30} is the old value plus the zero-extended immediate, modulo 2^16.
- R6: A carry out of the low-byte add is propagated into R31 in the same instruction.
- R7: After an add instruction, carry_o equals the carry out of bit 15 of the 16-bit sum. carry_o and pair_o never change during fetch.
- R8: With any opcode other than OPCODE, pair_o and carry_o keep their values, and the instruction still takes 11 cycles and raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 16 | Byte address, driven from the memory address register |
| mem_rd_o | output | 1 | Read strobe; memory answers in the next cycle |
| mem_rdata_i | input | 8 | Read data from memory |
| pair_o | output | 16 | Current value of {R31,R30} |
| carry_o | output | 1 | Carry flag |
| done_o | output | 1 | One-cycle pulse on the last execute cycle |

## Verification
The assertions check the following on every cycle:
- the 11-cycle spacing of the done pulse, using a cycle counter;
- that done never coincides with a memory read;
- that back-to-back reads step the address by one;
- that the pair and carry stay frozen during fetch and during a non-matching opcode.

Only the bench's scenarios can show the arithmetic values: the carry chain from the low byte into the high byte, the wrap past 0xFFFF that sets the carry, and a carry of 1 held across a non-matching opcode. For these, the bench scoreboards a long program against a reference model.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

  typedef enum logic [3:0] {
    ST_F0, ST_F1, ST_F2, ST_F3, ST_F4,
    ST_E0, ST_E1, ST_E2, ST_E3, ST_E4, ST_E5
  } state_e;

  typedef enum logic [1:0] {
    BUS_NONE, BUS_PC, BUS_MDR, BUS_RF
  } bus_src_e;

  typedef struct packed {
    bus_src_e bus_src;
    logic     mar_ld;
    logic     pc_inc;
    logic     mem_rd;
    logic     mdr_ld;
    logic     ac_ld_bus;
    logic     ac_add;
    logic     add_zero;
    logic     use_cin;
    logic     c_we;
    logic     ir_ld;
    logic     rf_we;
    logic     rf_hi;
  } ctrl_t;

endpackage

// File: rtl/wadd_alu.sv
module wadd_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
endmodule

// File: rtl/wadd_regfile.sv
module wadd_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int LO_IDX   = 30,
  parameter int HI_IDX   = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_hi_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2*DATA_W-1:0] pair_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [IDX_W-1:0]  idx;

  // single port: one index serves the read and the write
  assign idx = sel_hi_i ? IDX_W'(HI_IDX) : IDX_W'(LO_IDX);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (we_i && idx == IDX_W'(g))  regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[idx];
  assign pair_o  = {regs_q[HI_IDX], regs_q[LO_IDX]};
endmodule

// File: rtl/wadd_ctrl.sv
module wadd_ctrl
  import wadd_pkg::*;
#(
  parameter logic [7:0] OPCODE = 8'h3C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ir_i,
  output ctrl_t      ctrl_o,
  output state_e     state_o,
  output logic       done_o
);
  state_e state_q, state_d;
  logic   op_hit;

  assign op_hit = (ir_i == OPCODE);

  always_comb begin
    unique case (state_q)
      ST_F0:   state_d = ST_F1;
      ST_F1:   state_d = ST_F2;
      ST_F2:   state_d = ST_F3;
      ST_F3:   state_d = ST_F4;
      ST_F4:   state_d = ST_E0;
      ST_E0:   state_d = ST_E1;
      ST_E1:   state_d = ST_E2;
      ST_E2:   state_d = ST_E3;
      ST_E3:   state_d = ST_E4;
      ST_E4:   state_d = ST_E5;
      default: state_d = ST_F0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F0;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o.bus_src = BUS_NONE;
    unique case (state_q)
      // MAR <- PC ; PC++
      ST_F0: begin ctrl_o.bus_src = BUS_PC; ctrl_o.mar_ld = 1'b1; ctrl_o.pc_inc = 1'b1; end
      // read low byte ; MAR <- PC ; PC++
      ST_F1: begin
        ctrl_o.bus_src = BUS_PC; ctrl_o.mar_ld = 1'b1; ctrl_o.pc_inc = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      // MDR <- imm ; read high byte
      ST_F2: begin ctrl_o.mem_rd = 1'b1; ctrl_o.mdr_ld = 1'b1; end
      // AC <- MDR (imm) ; MDR <- opcode
      ST_F3: begin ctrl_o.bus_src = BUS_MDR; ctrl_o.ac_ld_bus = 1'b1; ctrl_o.mdr_ld = 1'b1; end
      // IR <- MDR
      ST_F4: begin ctrl_o.bus_src = BUS_MDR; ctrl_o.ir_ld = 1'b1; end
      // AC <- AC + R30 ; C
      ST_E0: begin ctrl_o.bus_src = BUS_RF; ctrl_o.ac_add = 1'b1; ctrl_o.c_we = op_hit; end
      // R30 <- AC
      ST_E1: begin ctrl_o.rf_we = op_hit; end
      // AC <- R31
      ST_E2: begin ctrl_o.bus_src = BUS_RF; ctrl_o.rf_hi = 1'b1; ctrl_o.ac_ld_bus = 1'b1; end
      // AC <- AC + 0 + C ; C
      ST_E3: begin
        ctrl_o.ac_add = 1'b1; ctrl_o.add_zero = 1'b1; ctrl_o.use_cin = 1'b1;
        ctrl_o.c_we   = op_hit;
      end
      // R31 <- AC
      ST_E4: begin ctrl_o.rf_hi = 1'b1; ctrl_o.rf_we = op_hit; end
      default: ;
    endcase
  end

  assign state_o = state_q;
  assign done_o  = (state_q == ST_E5);
endmodule

// File: rtl/wadd_datapath.sv
module wadd_datapath
  import wadd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int LO_IDX   = 30,
  parameter int HI_IDX   = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_t               ctrl_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   ir_o,
  output logic [2*DATA_W-1:0] pair_o,
  output logic                carry_o
);
  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pc_q, mar_q, bus;
  logic [DATA_W-1:0] mdr_q, ir_q, ac_q;
  logic              c_q;
  logic [DATA_W-1:0] rf_rdata, alu_b, alu_sum;
  logic              alu_cout;

  always_comb begin
    unique case (ctrl_i.bus_src)
      BUS_PC:  bus = pc_q;
      BUS_MDR: bus = {{PAD_W{1'b0}}, mdr_q};
      BUS_RF:  bus = {{PAD_W{1'b0}}, rf_rdata};
      default: bus = '0;
    endcase
  end

  assign alu_b = ctrl_i.add_zero ? '0 : bus[DATA_W-1:0];

  wadd_alu #(.W(DATA_W)) u_alu (
    .a_i   (ac_q),
    .b_i   (alu_b),
    .cin_i (ctrl_i.use_cin & c_q),
    .sum_o (alu_sum),
    .cout_o(alu_cout)
  );

  wadd_regfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_hi_i(ctrl_i.rf_hi),
    .we_i    (ctrl_i.rf_we),
    .wdata_i (ac_q),
    .rdata_o (rf_rdata),
    .pair_o  (pair_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
      c_q   <= 1'b0;
    end else begin
      if (ctrl_i.pc_inc)      pc_q  <= pc_q + ADDR_W'(1);
      if (ctrl_i.mar_ld)      mar_q <= bus;
      if (ctrl_i.mdr_ld)      mdr_q <= mem_rdata_i;
      if (ctrl_i.ir_ld)       ir_q  <= bus[DATA_W-1:0];
      if (ctrl_i.ac_add)      ac_q  <= alu_sum;
      else if (ctrl_i.ac_ld_bus) ac_q <= bus[DATA_W-1:0];
      if (ctrl_i.c_we)        c_q   <= alu_cout;
    end
  end

  assign mem_addr_o = mar_q;
  assign ir_o       = ir_q;
  assign carry_o    = c_q;
endmodule

// File: rtl/wadd_cpu.sv
module wadd_cpu
  import wadd_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         ADDR_W   = 16,
  parameter int         NUM_REGS = 32,
  parameter logic [7:0] OPCODE   = 8'h3C
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_rd_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [2*DATA_W-1:0] pair_o,
  output logic                carry_o,
  output logic                done_o
);
  localparam int HI_IDX = NUM_REGS - 1;
  localparam int LO_IDX = NUM_REGS - 2;

  ctrl_t       ctrl;
  state_e      state_w;
  logic [7:0]  ir_w;

  wadd_ctrl #(.OPCODE(OPCODE)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ir_i   (ir_w),
    .ctrl_o (ctrl),
    .state_o(state_w),
    .done_o (done_o)
  );

  wadd_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .mem_rdata_i(mem_rdata_i),
    .mem_addr_o (mem_addr_o),
    .ir_o       (ir_w),
    .pair_o     (pair_o),
    .carry_o    (carry_o)
  );

  assign mem_rd_o = ctrl.mem_rd;
endmodule

// File: rtl/wadd_cpu_chk.sv
module wadd_cpu_chk
  import wadd_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter int         ADDR_W = 16,
  parameter logic [7:0] OPCODE = 8'h3C
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic                mem_rd_o,
  input logic [2*DATA_W-1:0] pair_o,
  input logic                carry_o,
  input logic                done_o,
  input state_e              state_i,
  input logic [7:0]          ir_i
);
  logic [3:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc_q <= '0;
    else if (done_o) cyc_q <= '0;
    else             cyc_q <= cyc_q + 4'd1;
  end

  // R2
  done_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cyc_q == 4'd10);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  no_rd_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_rd_o);

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

  // R7
  fetch_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {ST_F0, ST_F1, ST_F2, ST_F3, ST_F4})
      |=> ($stable(carry_o) && $stable(pair_o)));

  // R8
  miss_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {ST_E0, ST_E1, ST_E2, ST_E3, ST_E4, ST_E5} && ir_i != OPCODE)
      |=> ($stable(carry_o) && $stable(pair_o)));
endmodule

bind wadd_cpu wadd_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPCODE(OPCODE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_addr_o(mem_addr_o),
  .mem_rd_o  (mem_rd_o),
  .pair_o    (pair_o),
  .carry_o   (carry_o),
  .done_o    (done_o),
  .state_i   (state_w),
  .ir_i      (ir_w)
);

// File: tb/tb_wadd_cpu.sv
module tb_wadd_cpu;
  localparam logic [7:0] OPC    = 8'h3C;
  localparam int         N_INSN = 300;
  localparam int         WD_MAX = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pair;
  logic        carry;
  logic        done;

  logic [7:0]  mem [1024];
  logic [16:0] exp_q [$];

  int checks = 0, failures = 0;
  int n_done = 0, cyc = 0, rd_ptr = 0, wd = 0;
  bit run = 1'b0, wd_hit = 1'b0;

  logic [15:0] m_pair = '0;
  logic        m_c = 1'b0;
  int          n_push = 0;

  always #4 clk = ~clk;

  wadd_cpu #(.OPCODE(OPC)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .pair_o(pair), .carry_o(carry), .done_o(done)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: place instruction, model it, push expectation
  task automatic push_insn(input logic [7:0] op, input logic [7:0] imm);
    logic [16:0] s;
    mem[2*n_push]   = imm;
    mem[2*n_push+1] = op;
    if (op == OPC) begin
      s = {1'b0, m_pair} + {9'b0, imm};
      m_pair = s[15:0];
      m_c    = s[16];
    end
    exp_q.push_back({m_c, m_pair});
    n_push++;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      chk(pair == 16'h0 && !carry && !done && !mem_rd, "R1", {pair, carry, done, mem_rd}, 0);
    end else if (run) begin
      // R2
      chk(done == (cyc % 11 == 10), "R2", done, (cyc % 11 == 10));
      // R4
      chk(mem_rd == (cyc % 11 == 1 || cyc % 11 == 2), "R4", mem_rd,
          (cyc % 11 == 1 || cyc % 11 == 2));
      if (cyc == 0) chk(!mem_rd && !done && pair == 0 && !carry, "R1", {pair, carry}, 0);
      if (mem_rd) begin
        // R3 (address 0 first per R1)
        chk(mem_addr == 16'(rd_ptr), "R3", mem_addr, rd_ptr);
        rd_ptr++;
      end
      if (done && exp_q.size() > 0) begin
        logic [16:0] e;
        e = exp_q.pop_front();
        // R5 R6 R7 R8
        chk({carry, pair} == e, "R5/R6/R7/R8", {carry, pair}, e);
        n_done++;
      end
      cyc++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == WD_MAX) begin
      wd_hit = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", n_done, N_INSN);
    end
  end

  initial begin
    bit noop_done;
    noop_done = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    push_insn(OPC, 8'h10);   // R5 -> 0010
    push_insn(OPC, 8'hF0);   // R6 low carry into high -> 0100
    push_insn(8'h55, 8'h33); // R8 unrelated op
    push_insn(8'h3D, 8'hFF); // R8 near-miss op
    push_insn(OPC, 8'hFF);   // R5 -> 01FF
    push_insn(OPC, 8'h01);   // R6 -> 0200
    push_insn(OPC, 8'h00);   // R5 zero imm
    while (n_push < N_INSN) begin
      if (m_c && !noop_done) begin
        push_insn(8'h00, 8'h77); // R8 carry of 1 held over a miss
        noop_done = 1'b1;
      end else begin
        push_insn(OPC, 8'hFF);   // R7 walk past FFFF
      end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run = 1'b1;
    wait (n_done == N_INSN || wd_hit);
    @(negedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule